// File: doc/BRIEF.md
# Atomic Staged Configuration Committer

This block holds a configuration blob that is loaded one byte at a time into a staging store. On a commit command it checks the blob, and it makes the blob's parameter bytes active only when every check passes. The checker walks the staged bytes one per clock. While it walks, it folds each byte into a running CRC and follows the chain of type-length records that starts after the header. It then gives a single numeric verdict. A passing verdict loads every active-configuration register on one clock edge and sets the sticky "applied" flag. One cycle later it sends a one-cycle clear pulse to the tile array. A failing verdict changes no active state.

The staged blob has this layout, with all multi-byte fields little-endian. Bytes 0..3 hold the magic word. Byte 4 holds the format version. Byte 5 is reserved. Bytes 6..7 hold the total blob length. Records start at byte 8, each one a type byte, a length byte and that many value bytes. The last four bytes hold the CRC. A topology record (type 0x01) carries one byte, the tile count. A parameter record (type 0x02) carries exactly `CFG_BYTES` bytes, and these become `cfg_active`, with the record's first value byte in bits 7:0. The commit command is honoured only while no flash cycle is running and no check is in progress.

Top module: `cfg_commit`

## Requirements
- R1: After reset, `done`, `tile_rst`, `applied`, `busy` and `err_code` are 0 and `cfg_active` is all zero.
- R2: The staging length equals the address of the most recently accepted staging write plus one, and it is 0 after reset. A commit with staging length 0 reports code 9, whatever the staged bytes hold.
- R3: For a blob that passes every check, `done` pulses with code 0. On the same edge `cfg_active` takes the parameter record's value bytes and `applied` becomes 1. `applied` never returns to 0.
- R4: `tile_rst` is high for exactly the one cycle after a `done` with code 0, and it is never high at any other time.
- R5: A verdict with a non-zero code leaves `cfg_active` and `applied` unchanged.
- R6: The error codes are: 1 when the magic word is not `MAGIC`; 2 when the version byte is not `VERSION`; 3 when the blob is shorter than 12 bytes or the length field differs from the staging length; 4 when the topology or parameter record is absent; 5 when the topology length is not 1, the parameter length is not `CFG_BYTES`, or the record chain does not end exactly at the CRC field; 6 on a CRC mismatch; 7 when the reserved byte is non-zero; 8 when the topology value is not `TILE_COUNT`.
- R7: When more than one check fails, the lowest code is reported.
- R8: The CRC is CRC-32, reflected, with polynomial 0x04C11DB7, initial value 0xFFFFFFFF and a final inversion. It covers every byte before the trailing 4-byte CRC field.
- R9: A commit command while `flash_busy` is high is ignored: no check starts and no `done` follows.
- R10: While `busy` is high, further commit commands and staging writes are ignored, and the running check completes on the bytes it started with.
- R11: `done` lasts one cycle, and `err_code` holds the latest verdict until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Staging byte write strobe |
| wr_addr | input | 6 | Staging byte address (log2 DEPTH) |
| wr_data | input | 8 | Staging byte value |
| bake | input | 1 | Commit command strobe |
| flash_busy | input | 1 | High while a flash cycle is running |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle verdict pulse |
| err_code | output | 4 | Latest verdict code (0 = committed) |
| applied | output | 1 | Sticky flag, set by the first successful commit |
| cfg_active | output | CFG_BYTES*8 | Active configuration bytes |
| tile_rst | output | 1 | Runtime clear pulse to the tile array |

## Verification
Two events can fall in the same cycle. A commit command can arrive while a flash cycle is running, and a staging write can arrive while a check is walking the very bytes it would overwrite. The bench raises the command with `flash_busy` held high and expects no verdict at all. It then starts a good blob and, mid-walk, both repeats the command and writes a different value into a parameter byte. The verdict must be a single code 0, and `cfg_active` must hold the bytes that were staged before the walk began. Several blobs also carry two faults at once, and in each case the lower code must be reported.

// File: rtl/cfgc_pkg.sv
package cfgc_pkg;

    typedef enum logic [3:0] {
        E_OK       = 4'd0,
        E_MAGIC    = 4'd1,
        E_VERSION  = 4'd2,
        E_LENGTH   = 4'd3,
        E_MISSING  = 4'd4,
        E_RECLEN   = 4'd5,
        E_CRC      = 4'd6,
        E_RESERVED = 4'd7,
        E_TOPOLOGY = 4'd8,
        E_EMPTY    = 4'd9
    } err_e;

    typedef enum logic [1:0] {S_IDLE, S_SCAN, S_EVAL} scan_st_e;

    localparam int          HDR_BYTES     = 8;
    localparam int          CRC_BYTES     = 4;
    localparam logic [7:0]  REC_TOPO      = 8'h01;
    localparam logic [7:0]  REC_PARAM     = 8'h02;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [31:0] CRC_INIT      = 32'hFFFF_FFFF;

    // Facts gathered while walking the record chain
    typedef struct packed {
        logic        seen_topo;
        logic        topo_len_ok;
        logic [7:0]  topo_val;
        logic        seen_par;
        logic        par_len_ok;
        logic [15:0] par_start;
        logic [15:0] next_rec;
    } walk_t;

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int k = 0; k < 8; k++)
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        return r;
    endfunction

endpackage

// File: rtl/cfgc_stage_buf.sv
module cfgc_stage_buf #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [7:0]         wr_data,
    input  logic               lock,
    output logic [DEPTH*8-1:0] mem_flat,
    output logic [AW:0]        stage_len
);
    logic [7:0] mem [DEPTH];
    logic       wr_ok;

    assign wr_ok = wr_en && !lock && (int'(wr_addr) < DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_len <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (wr_ok) begin
            mem[wr_addr] <= wr_data;
            stage_len    <= {1'b0, wr_addr} + 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign mem_flat[g*8 +: 8] = mem[g];
    end

    // R10: writes are dropped while a check runs
    a_r10_len_frozen: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(stage_len));

endmodule

// File: rtl/cfgc_checker.sv
module cfgc_checker
    import cfgc_pkg::*;
#(
    parameter int          DEPTH      = 64,
    parameter int          CFG_BYTES  = 8,
    parameter int          TILE_COUNT = 16,
    parameter logic [31:0] MAGIC      = 32'hC0F1_6A7E,
    parameter logic [7:0]  VERSION    = 8'h01,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bake,
    input  logic                   flash_busy,
    input  logic [DEPTH*8-1:0]     mem_flat,
    input  logic [AW:0]            stage_len,
    output logic                   busy,
    output logic                   v_valid,
    output err_e                   v_code,
    output logic [CFG_BYTES*8-1:0] par_bytes
);
    scan_st_e    st;
    logic [15:0] len_q, idx;
    logic [31:0] crc_q;
    walk_t       walk;
    logic [15:0] body_end;
    logic [7:0]  cur, nx1, nx2;
    logic [31:0] magic_rd, crc_rd;

    function automatic logic [7:0] get(input logic [15:0] a);
        logic [7:0] r;
        r = 8'h00;
        if (int'(a) < DEPTH) r = mem_flat[{a[AW-1:0], 3'b000} +: 8];
        return r;
    endfunction

    assign busy     = (st != S_IDLE);
    assign body_end = (len_q >= 16'd4) ? len_q - 16'd4 : 16'd0;
    assign cur      = get(idx);
    assign nx1      = get(idx + 16'd1);
    assign nx2      = get(idx + 16'd2);
    assign magic_rd = {get(16'd3), get(16'd2), get(16'd1), get(16'd0)};
    assign crc_rd   = {get(body_end + 16'd3), get(body_end + 16'd2),
                       get(body_end + 16'd1), get(body_end)};

    for (genvar k = 0; k < CFG_BYTES; k++) begin : g_par
        assign par_bytes[k*8 +: 8] = get(walk.par_start + 16'(k));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            len_q <= '0;
            idx   <= '0;
            crc_q <= CRC_INIT;
            walk  <= '0;
        end else begin
            case (st)
                S_IDLE: if (bake && !flash_busy) begin
                    len_q <= 16'(stage_len);
                    idx   <= '0;
                    crc_q <= CRC_INIT;
                    walk  <= '0;
                    walk.next_rec <= 16'(HDR_BYTES);
                    st    <= (stage_len == '0) ? S_EVAL : S_SCAN;
                end
                S_SCAN: begin
                    if (idx < body_end) crc_q <= crc_byte(crc_q, cur);
                    if (idx >= 16'(HDR_BYTES) && idx == walk.next_rec && idx < body_end) begin
                        walk.next_rec <= idx + 16'd2 + {8'd0, nx1};
                        if (cur == REC_TOPO) begin
                            walk.seen_topo   <= 1'b1;
                            walk.topo_len_ok <= (nx1 == 8'd1);
                            walk.topo_val    <= nx2;
                        end
                        if (cur == REC_PARAM) begin
                            walk.seen_par   <= 1'b1;
                            walk.par_len_ok <= (nx1 == 8'(CFG_BYTES));
                            walk.par_start  <= idx + 16'd2;
                        end
                    end
                    idx <= idx + 16'd1;
                    if (idx + 16'd1 == len_q) st <= S_EVAL;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Priority verdict: empty first, then lowest code wins
    always_comb begin
        v_valid = (st == S_EVAL);
        if (len_q == 16'd0)                                   v_code = E_EMPTY;
        else if (magic_rd != MAGIC)                           v_code = E_MAGIC;
        else if (get(16'd4) != VERSION)                       v_code = E_VERSION;
        else if (len_q < 16'(HDR_BYTES + CRC_BYTES) ||
                 {get(16'd7), get(16'd6)} != len_q)           v_code = E_LENGTH;
        else if (!(walk.seen_topo && walk.seen_par))          v_code = E_MISSING;
        else if (!walk.topo_len_ok || !walk.par_len_ok ||
                 walk.next_rec != body_end)                   v_code = E_RECLEN;
        else if (~crc_q != crc_rd)                            v_code = E_CRC;
        else if (get(16'd5) != 8'h00)                         v_code = E_RESERVED;
        else if (walk.topo_val != 8'(TILE_COUNT))             v_code = E_TOPOLOGY;
        else                                                  v_code = E_OK;
    end

    // R9: a command during a flash cycle starts nothing
    a_r9_flash_blocks: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && flash_busy) |=> (st == S_IDLE));
    // R10: the latched length is held for the whole check
    a_r10_len_held: assert property (@(posedge clk) disable iff (rst)
        (st != S_IDLE) |=> $stable(len_q));

endmodule

// File: rtl/cfg_commit.sv
module cfg_commit
    import cfgc_pkg::*;
#(
    parameter int          DEPTH      = 64,
    parameter int          CFG_BYTES  = 8,
    parameter int          TILE_COUNT = 16,
    parameter logic [31:0] MAGIC      = 32'hC0F1_6A7E,
    parameter logic [7:0]  VERSION    = 8'h01,
    localparam int AW   = $clog2(DEPTH),
    localparam int CFGW = CFG_BYTES * 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [7:0]      wr_data,
    input  logic            bake,
    input  logic            flash_busy,
    output logic            busy,
    output logic            done,
    output logic [3:0]      err_code,
    output logic            applied,
    output logic [CFGW-1:0] cfg_active,
    output logic            tile_rst
);
    logic [DEPTH*8-1:0] mem_flat;
    logic [AW:0]        stage_len;
    logic               v_valid;
    err_e               v_code;
    logic [CFGW-1:0]    par_bytes;
    logic               done_q, applied_q, tile_rst_q;
    err_e               err_q;
    logic [CFGW-1:0]    cfg_q;

    cfgc_stage_buf #(.DEPTH(DEPTH)) u_stage (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lock(busy), .mem_flat(mem_flat), .stage_len(stage_len)
    );

    cfgc_checker #(
        .DEPTH(DEPTH), .CFG_BYTES(CFG_BYTES), .TILE_COUNT(TILE_COUNT),
        .MAGIC(MAGIC), .VERSION(VERSION)
    ) u_check (
        .clk(clk), .rst(rst), .bake(bake), .flash_busy(flash_busy),
        .mem_flat(mem_flat), .stage_len(stage_len), .busy(busy),
        .v_valid(v_valid), .v_code(v_code), .par_bytes(par_bytes)
    );

    // Shadow registers: all loaded on the verdict edge
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q     <= 1'b0;
            err_q      <= E_OK;
            applied_q  <= 1'b0;
            cfg_q      <= '0;
            tile_rst_q <= 1'b0;
        end else begin
            done_q     <= v_valid;
            tile_rst_q <= done_q && (err_q == E_OK);
            if (v_valid) err_q <= v_code;
            if (v_valid && v_code == E_OK) begin
                cfg_q     <= par_bytes;
                applied_q <= 1'b1;
            end
        end
    end

    assign done       = done_q;
    assign err_code   = err_q;
    assign applied    = applied_q;
    assign cfg_active = cfg_q;
    assign tile_rst   = tile_rst_q;

    // R3: applied is sticky
    a_r3_applied_sticky: assert property (@(posedge clk) disable iff (rst)
        applied_q |=> applied_q);
    // R5: active config moves only with a passing verdict
    a_r5_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_q) |-> (done_q && err_q == E_OK));
    // R4: clear pulse follows a commit
    a_r4_clear_follows: assert property (@(posedge clk) disable iff (rst)
        (done_q && err_q == E_OK) |=> tile_rst_q);
    a_r4_clear_only_after: assert property (@(posedge clk) disable iff (rst)
        tile_rst_q |-> $past(done_q && err_q == E_OK));
    // R11: one-cycle verdict pulse with a defined code
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    a_r6_code_range: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (err_q <= E_EMPTY));

endmodule

// File: tb/cfg_commit_test.sv
module cfg_commit_test;
    localparam int          CLK_PERIOD = 10;
    localparam int          DEPTH      = 64;
    localparam int          CFG_BYTES  = 8;
    localparam int          TILE_COUNT = 16;
    localparam logic [31:0] MAGIC      = 32'hC0F1_6A7E;
    localparam logic [7:0]  VERSION    = 8'h01;

    logic        clk = 1'b0, rst = 1'b1;
    logic        wr_en = 1'b0, bake = 1'b0, flash_busy = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy, done, applied, tile_rst;
    logic [3:0]  err_code;
    logic [63:0] cfg_active;

    cfg_commit #(.DEPTH(DEPTH), .CFG_BYTES(CFG_BYTES), .TILE_COUNT(TILE_COUNT),
                 .MAGIC(MAGIC), .VERSION(VERSION)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bake(bake), .flash_busy(flash_busy), .busy(busy), .done(done),
        .err_code(err_code), .applied(applied), .cfg_active(cfg_active), .tile_rst(tile_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { logic [3:0] code; logic [63:0] cfg; bit appl; } exp_t;
    exp_t        q[$];
    int          checks = 0, errors = 0, done_cnt = 0;
    bit          want_rst = 0;
    logic [7:0]  blob [0:63];
    int          blen;
    logic [63:0] new_cfg, model_cfg = '0;
    bit          model_appl = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] crc_over(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'd0, blob[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic build(input logic [31:0] mg, input logic [7:0] ver, input logic [7:0] res,
                         input int len_adj, input logic [7:0] t1, input logic [7:0] l1,
                         input logic [7:0] v1, input logic [7:0] t2, input logic [7:0] l2,
                         input logic [7:0] seed, input bit bad_crc);
        int p;
        logic [31:0] c;
        for (int i = 0; i < 4; i++) blob[i] = mg[i*8 +: 8];
        blob[4] = ver; blob[5] = res;
        p = 8;
        blob[p] = t1; blob[p+1] = l1; p += 2;
        for (int j = 0; j < int'(l1); j++) begin blob[p] = (j == 0) ? v1 : 8'h00; p++; end
        blob[p] = t2; blob[p+1] = l2; p += 2;
        for (int j = 0; j < int'(l2); j++) begin
            blob[p] = seed + 8'(j);
            if (j < CFG_BYTES) new_cfg[j*8 +: 8] = seed + 8'(j);
            p++;
        end
        blen = p + 4;
        blob[6] = 8'((blen + len_adj) & 255);
        blob[7] = 8'((blen + len_adj) >> 8);
        c = crc_over(p);
        if (bad_crc) c = c ^ 32'h1;
        for (int i = 0; i < 4; i++) blob[p+i] = c[i*8 +: 8];
    endtask

    task automatic load_blob();
        for (int i = 0; i < blen; i++) begin
            @(posedge clk); #1;
            wr_en = 1'b1; wr_addr = 6'(i); wr_data = blob[i];
        end
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic push_exp(input logic [3:0] code);
        exp_t e;
        if (code == 4'd0) begin model_cfg = new_cfg; model_appl = 1; end
        e.code = code; e.cfg = model_cfg; e.appl = model_appl;
        q.push_back(e);
    endtask

    task automatic pulse_bake();
        @(posedge clk); #1; bake = 1'b1;
        @(posedge clk); #1; bake = 1'b0;
    endtask

    task automatic run(input logic [3:0] code);
        int target;
        target = done_cnt + 1;
        load_blob();
        push_exp(code);
        pulse_bake();
        wait (done_cnt == target);
        repeat (3) @(posedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (want_rst || tile_rst)
                check(tile_rst == want_rst, "R4 tile_rst", 64'(tile_rst), 64'(want_rst));
            want_rst = 0;
            if (done) begin
                done_cnt++;
                if (q.size() == 0) begin
                    check(1'b0, "R9/R10 unexpected done", 64'(err_code), 64'hFFFF);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(err_code == e.code, "R6/R7 err_code", 64'(err_code), 64'(e.code));
                    check(cfg_active == e.cfg, "R3/R5 cfg_active", cfg_active, e.cfg);
                    check(applied == e.appl, "R3/R5 applied", 64'(applied), 64'(e.appl));
                    want_rst = (e.code == 4'd0);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int target;
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(done == 0 && tile_rst == 0 && applied == 0 && busy == 0, "R1 flags",
              {60'd0, done, tile_rst, applied, busy}, 64'd0);
        check(err_code == 0, "R1 err_code", 64'(err_code), 64'd0);
        check(cfg_active == 0, "R1 cfg_active", cfg_active, 64'd0);

        // R2 empty staging
        target = done_cnt + 1;
        push_exp(4'd9);
        pulse_bake();
        wait (done_cnt == target);
        repeat (2) @(posedge clk);

        // R3 R8 good blob
        build(MAGIC, VERSION, 8'h00, 0, 8'h01, 8'd1, 8'd16, 8'h02, 8'd8, 8'h10, 0);
        run(4'd0);
        // R6 individual faults
        build(32'h1234_5678, VERSION, 8'h00, 0, 8'h01, 8'd1, 8'd16, 8'h02, 8'd8, 8'h20, 0);
        run(4'd1);
        // R7 version and reserved both bad -> 2
        build(MAGIC, 8'h07, 8'h55, 0, 8'h01, 8'd1, 8'd16, 8'h02, 8'd8, 8'h21, 0);
        run(4'd2);
        build(MAGIC, VERSION, 8'h00, 1, 8'h01, 8'd1, 8'd16, 8'h02, 8'd8, 8'h22, 0);
        run(4'd3);
        build(MAGIC, VERSION, 8'h00, 0, 8'h01, 8'd1, 8'd16, 8'h03, 8'd8, 8'h23, 0);
        run(4'd4);
        build(MAGIC, VERSION, 8'h00, 0, 8'h01, 8'd2, 8'd16, 8'h02, 8'd8, 8'h24, 0);
        run(4'd5);
        build(MAGIC, VERSION, 8'h00, 0, 8'h01, 8'd1, 8'd16, 8'h02, 8'd8, 8'h25, 1);
        run(4'd6);   // R8 crc mismatch
        build(MAGIC, VERSION, 8'h01, 0, 8'h01, 8'd1, 8'd16, 8'h02, 8'd8, 8'h26, 0);
        run(4'd7);
        // R7 crc bad and topology wrong -> 6
        build(MAGIC, VERSION, 8'h00, 0, 8'h01, 8'd1, 8'd9, 8'h02, 8'd8, 8'h27, 1);
        run(4'd6);
        build(MAGIC, VERSION, 8'h00, 0, 8'h01, 8'd1, 8'd9, 8'h02, 8'd8, 8'h28, 0);
        run(4'd8);
        // R11 code held
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(err_code == 4'd8 && done == 0, "R11 code held", 64'(err_code), 64'd8);

        // R9 command during flash
        target = done_cnt;
        build(MAGIC, VERSION, 8'h00, 0, 8'h01, 8'd1, 8'd16, 8'h02, 8'd8, 8'h40, 0);
        load_blob();
        flash_busy = 1'b1;
        pulse_bake();
        repeat (40) @(posedge clk);
        @(negedge clk);
        check(done_cnt == target && busy == 0, "R9 no check started",
              64'(done_cnt), 64'(target));
        @(posedge clk); #1; flash_busy = 1'b0;

        // R10 command and write during a running check
        build(MAGIC, VERSION, 8'h00, 0, 8'h01, 8'd1, 8'd16, 8'h02, 8'd8, 8'h50, 0);
        target = done_cnt + 1;
        load_blob();
        push_exp(4'd0);
        pulse_bake();
        repeat (2) @(posedge clk); #1;
        bake = 1'b1; wr_en = 1'b1; wr_addr = 6'd13; wr_data = 8'hEE;
        @(posedge clk); #1;
        bake = 1'b0; wr_en = 1'b0;
        wait (done_cnt == target);
        repeat (40) @(posedge clk);
        @(negedge clk);
        check(done_cnt == target, "R10 single verdict", 64'(done_cnt), 64'(target));
        check(q.size() == 0, "R10 scoreboard drained", 64'(q.size()), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule